// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is a purely combinational integer unit for a simple processor datapath. It takes two operand words and a four-bit operation code. It returns a result word and a flag that is high when that result is zero. The unit can perform bitwise AND, bitwise OR, addition, subtraction and a signed less-than comparison.

One adder serves every arithmetic operation. Subtraction feeds the adder the complement of the second operand and a carry-in of one. The comparison reads its answer from that same difference, with a correction for signed overflow. The zero flag lets a branch-on-equal decision come straight from a subtraction.

The unit holds no state and has no clock. Every output follows its inputs within the same cycle. Arithmetic wraps at the word width and raises no exception. Codes outside the five defined ones give a zero result.

Top module: `alu_core`

## Requirements
- R1: With op_i = 4'b0000 the result is the bitwise AND of a_i and b_i.
- R2: With op_i = 4'b0001 the result is the bitwise OR of a_i and b_i.
- R3: With op_i = 4'b0010 the result is a_i + b_i modulo 2^32, so 32'hFFFFFFFF + 1 gives 0.
- R4: With op_i = 4'b0110 the result is a_i + ~b_i + 1 modulo 2^32, that is a_i - b_i with wrap-around.
- R5: With op_i = 4'b0111 the result is 32'd1 when a_i is less than b_i as two's-complement signed values and 32'd0 otherwise. Bits 31..1 are always zero, so 32'h80000000 counts as less than 0.
- R6: zero_o is high exactly when all 32 bits of result_o are zero, whatever the operation.
- R7: Every op_i value other than 0000, 0001, 0010, 0110 and 0111 gives result_o = 0, and therefore zero_o = 1.
- R8: The outputs depend only on the present inputs, and they settle in the same cycle the inputs change, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (subtrahend for subtraction and comparison) |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The result and the zero flag are produced in the same evaluation. The critical case is when both must agree at a boundary. Subtracting equal operands, wrapping an addition to zero, a false comparison, an AND of disjoint bit patterns and an unused operation code all drive the result to zero and the flag high at once. In each case the bench compares both outputs against values it works out from the requirements. A randomized pass with a reference model then covers every operation code, including the signed-overflow cases of the comparison.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111
    } alu_op_e;

    // True for the five defined operation codes.
    function automatic logic op_is_legal(input logic [OP_W-1:0] code);
        return (code == OP_AND) || (code == OP_OR) || (code == OP_ADD) ||
               (code == OP_SUB) || (code == OP_SLT);
    endfunction

endpackage

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs_i,
    input  logic [WIDTH-1:0] rhs_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o
);

    // One gate pair per bit position.
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign and_o[g] = lhs_i[g] & rhs_i[g];
        assign or_o[g]  = lhs_i[g] | rhs_i[g];
    end

    // R1: an AND bit can be high only where both operands are high
    always_comb begin
        a_r1_and_subset: assert ((and_o & ~lhs_i) == '0 && (and_o & ~rhs_i) == '0);
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs_i,
    input  logic [WIDTH-1:0] rhs_i,
    input  logic             negate_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             less_o
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] rhs_eff;
    logic [WIDTH-1:0] carry_in;
    logic             ovf;

    // Subtraction: invert the second operand and add one through the carry-in.
    assign rhs_eff  = negate_i ? ~rhs_i : rhs_i;
    assign carry_in = {{(WIDTH-1){1'b0}}, negate_i};
    assign sum_o    = lhs_i + rhs_eff + carry_in;

    // Signed overflow of the difference: the operand signs differ and the sign flips.
    assign ovf    = (lhs_i[MSB] ^ rhs_i[MSB]) & (sum_o[MSB] ^ lhs_i[MSB]);
    assign less_o = sum_o[MSB] ^ ovf;

    // R5: the sign-corrected difference agrees with a signed compare
    always_comb begin
        if (negate_i) begin
            a_r5_less_matches: assert (less_o == ($signed(lhs_i) < $signed(rhs_i)));
        end
    end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             zero_o
);

    assign zero_o = ~|word_i;

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [OP_W-1:0]  op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o
);

    alu_op_e          op;
    logic [WIDTH-1:0] and_w;
    logic [WIDTH-1:0] or_w;
    logic [WIDTH-1:0] sum_w;
    logic             less_w;
    logic             negate;

    assign op     = alu_op_e'(op_i);
    assign negate = (op_i == OP_SUB) || (op_i == OP_SLT);

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .lhs_i (a_i),
        .rhs_i (b_i),
        .and_o (and_w),
        .or_o  (or_w)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .lhs_i    (a_i),
        .rhs_i    (b_i),
        .negate_i (negate),
        .sum_o    (sum_w),
        .less_o   (less_w)
    );

    // Result select; codes outside the set give zero.
    always_comb begin
        unique case (op)
            OP_AND:  result_o = and_w;
            OP_OR:   result_o = or_w;
            OP_ADD:  result_o = sum_w;
            OP_SUB:  result_o = sum_w;
            OP_SLT:  result_o = {{(WIDTH-1){1'b0}}, less_w};
            default: result_o = '0;
        endcase
    end

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .word_i (result_o),
        .zero_o (zero_o)
    );

    always_comb begin
        if (op_i == OP_ADD) begin
            a_r3_add_inverse: assert (result_o - b_i == a_i);   // R3
        end
        if (op_i == OP_SUB) begin
            a_r4_sub_inverse: assert (result_o + b_i == a_i);   // R4
        end
        if (op_i == OP_SLT) begin
            a_r5_slt_shape: assert ($countones(result_o) <= 1 && result_o[0] == ($signed(a_i) < $signed(b_i)));
        end
        if (!op_is_legal(op_i)) begin
            a_r7_unused_zero: assert (result_o == '0);
        end
        a_r6_zero_flag: assert (zero_o == ($countones(result_o) == 0));
    end

endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;

    localparam int unsigned W        = 32;
    localparam int unsigned N_VEC    = 17;
    localparam int unsigned N_RAND   = 4000;
    localparam int unsigned WD_LIMIT = 100000;

    typedef struct packed {
        logic [3:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] res;
        logic         zf;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{4'b0000, 32'hF0F0F0F0, 32'h0FF00FF0, 32'h00F000F0, 1'b0}, // R1
        '{4'b0000, 32'hAAAAAAAA, 32'h55555555, 32'h00000000, 1'b1}, // R1 R6
        '{4'b0001, 32'h12340000, 32'h00005678, 32'h12345678, 1'b0}, // R2
        '{4'b0001, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1}, // R2 R6
        '{4'b0010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1}, // R3 wrap
        '{4'b0010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0}, // R3 no flag
        '{4'b0110, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0}, // R4
        '{4'b0110, 32'h12345678, 32'h12345678, 32'h00000000, 1'b1}, // R4 equal
        '{4'b0110, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0}, // R4 wrap
        '{4'b0111, 32'h80000000, 32'h00000000, 32'h00000001, 1'b0}, // R5
        '{4'b0111, 32'h00000000, 32'h80000000, 32'h00000000, 1'b1}, // R5
        '{4'b0111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0}, // R5
        '{4'b0111, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b1}, // R5 overflow
        '{4'b0111, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1}, // R5 equal
        '{4'b0111, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 1'b0}, // R5 overflow
        '{4'b0011, 32'hDEADBEEF, 32'h00000001, 32'h00000000, 1'b1}, // R7
        '{4'b1111, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1}  // R7
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [3:0]   op = '0;
    logic [W-1:0] result;
    logic         zero;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned cycles   = 0;
    bit          done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    alu_core #(.WIDTH(W)) dut (
        .a_i      (a),
        .b_i      (b),
        .op_i     (op),
        .result_o (result),
        .zero_o   (zero)
    );

    // Reference built from the requirements.
    function automatic logic [W-1:0] model(input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
        case (c)
            4'b0000: return x & y;
            4'b0001: return x | y;
            4'b0010: return x + y;
            4'b0110: return x - y;
            4'b0111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp_r, input logic exp_z);
        n_checks++;
        if (result !== exp_r || zero !== exp_z) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h: result=%h zero=%b expected result=%h zero=%b",
                     req, op, a, b, result, zero, exp_r, exp_z);
        end
    endtask

    // Drive on the rising edge, judge on the falling edge.
    task automatic apply(input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
        @(posedge clk);
        op = c; a = x; b = y;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT && !done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WD_LIMIT);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Initial state: all inputs zero selects AND of zeros (R1, R6)
        @(negedge clk);
        check("R1_R6_initial", '0, 1'b1);

        // Vector table
        for (int i = 0; i < N_VEC; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b);
            check($sformatf("table[%0d] R1..R7", i), VECS[i].res, VECS[i].zf);
        end

        // R7: every unused code leaves result zero, flag high
        for (int c = 0; c < 16; c++) begin
            apply(4'(c), 32'hCAFEF00D, 32'h0BADBEEF);
            check("R7_all_codes", model(4'(c), a, b), model(4'(c), a, b) == '0);
        end

        // R8: inputs change while the clock is held mid-phase, outputs follow at once
        @(posedge clk);
        op = 4'b0010; a = 32'd10; b = 32'd20;
        #1;
        check("R8_no_clock", 32'd30, 1'b0);
        a = 32'hFFFFFFEC;
        #1;
        check("R8_follow", 32'd0, 1'b1);

        // R6 coincidence: subtract equal values, flag with zero result
        apply(4'b0110, 32'h80000000, 32'h80000000);
        check("R4_R6_equal", '0, 1'b1);

        // Randomized pass over all codes with the reference model (R1..R7)
        for (int k = 0; k < N_RAND; k++) begin
            logic [3:0]   c;
            logic [W-1:0] x;
            logic [W-1:0] y;
            c = 4'($urandom_range(0, 15));
            x = $urandom();
            y = (k % 8 == 0) ? x : $urandom();
            if (k % 16 == 1) x = {1'b1, 31'd0};
            if (k % 16 == 2) y = {1'b0, {31{1'b1}}};
            apply(c, x, y);
            check("R1_R7_random", model(c, x, y), model(c, x, y) == '0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule